// File: doc/BRIEF.md
# Receive Descriptor Timestamp and Sequence Stamper

This block sits on the receive path between the packet classifier and the writer that posts descriptors into notification rings. It runs its own time-of-day counter, split into a 32-bit nanoseconds word and a 32-bit seconds word. Every start-of-packet strobe from the MAC side captures the current time into a small in-order queue. Each descriptor that arrives later from the classifier takes the oldest queued time, so a packet's time always reflects its arrival, even when classification takes a long time.

The classifier sets two enables per descriptor. With the time enable set, the block replaces the descriptor's time fields with the captured time. With it clear, the classifier's own contents pass through. With the sequence enable set, a packet sequence number is written into the 48-bit sequence field as the descriptor leaves. With it clear, the classifier's value passes through. A 2-bit destination code chooses between three outcomes: the descriptor is dropped, or it is delivered with the packet, or it is delivered alone. The sequence counter counts delivered descriptors only. It counts them whether or not their sequence enable is set.

Both descriptor ports are valid/ready. The input side transfers when `in_valid` and `in_ready` are both high on a clock edge. The output side transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, a presented output holds all its fields unchanged. `in_ready` rises only when a captured time is waiting and the single output slot is free or is being emptied in the same cycle. `sop` and `ns_step` are plain control inputs without a handshake.

Top module: `rx_desc_stamper`

## Requirements
- R1: After reset, `out_valid` and `in_ready` are low, the time counter reads 0 s 0 ns, and the sequence counter is 0.
- R2: On each clock edge out of reset, nanoseconds advance by `ns_step`. When the sum reaches `NS_WRAP` (default 1,000,000,000), nanoseconds become the sum minus `NS_WRAP` and seconds increase by one. `ns_step` must stay below `NS_WRAP`.
- R3: A `sop` high on a clock edge captures the time held before that edge. Captured times are handed out in arrival order, one to each accepted descriptor, dropped descriptors included.
- R4: When `in_ts_en` is 1, the output time fields equal the captured time. When it is 0, they equal `in_ts_ns` and `in_ts_sec` unchanged.
- R5: When `in_seq_en` is 1, `out_seq` equals the sequence counter at the moment of acceptance. When it is 0, `out_seq` equals `in_seq` unchanged.
- R6: The sequence counter advances by exactly one for each accepted descriptor that is delivered, whatever its sequence enable. The first delivered descriptor sees 0.
- R7: Destination code 0 (drop both) and code 3 (reserved, treated as drop) produce no output and leave the sequence counter unchanged. They still consume a captured time.
- R8: Code 1 (deliver packet and descriptor) and code 2 (deliver descriptor only) are delivered, and `out_dest` carries the code unchanged.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every output field holds. `out_valid` falls only after a transfer with no new descriptor accepted.
- R10: At most `TS_DEPTH` captured times are held. A `sop` arriving while the queue is full is ignored, even when a time leaves the queue on the same edge.
- R11: `in_ready` is high exactly when a captured time is waiting and either `out_valid` is low or `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ns_step | input | 32 | Nanoseconds added per clock |
| sop | input | 1 | Start-of-packet strobe from the MAC side |
| in_valid | input | 1 | Classifier descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_ts_en | input | 1 | Replace the time fields with the captured time |
| in_seq_en | input | 1 | Replace the sequence field with the counter |
| in_dest | input | 2 | 0 drop, 1 deliver both, 2 descriptor only, 3 drop |
| in_ts_ns | input | 32 | Classifier's nanoseconds contents |
| in_ts_sec | input | 32 | Classifier's seconds contents |
| in_seq | input | SEQ_W | Classifier's sequence-field contents |
| out_valid | output | 1 | Final descriptor valid |
| out_ready | input | 1 | Ring writer can take the descriptor |
| out_dest | output | 2 | Delivered destination code (1 or 2) |
| out_ts_ns | output | 32 | Final nanoseconds field |
| out_ts_sec | output | 32 | Final seconds field |
| out_seq | output | SEQ_W | Final sequence field |

## Verification
A wrong time count shows up in the time fields of the next descriptor that has its time enable set. If the capture queue has slipped by one entry, every later stamped descriptor is off by the gap between two starts of packet. A sequence counter that advances on a drop, or fails to advance on a delivery, makes every later sequence-enabled output wrong by one. An output register that does not hold under back-pressure changes fields before the transfer completes. A mistake in the ready logic shows on `in_ready` in the very cycle it happens. The bench sweeps every combination of enables and destination codes under several back-pressure patterns, and it runs time steps that force rollover often, so each of these faults appears within a few descriptors.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int NS_W  = 32;
  localparam int SEC_W = 32;

  typedef enum logic [1:0] {
    DST_DROP = 2'd0,
    DST_BOTH = 2'd1,
    DST_DESC = 2'd2,
    DST_RSV  = 2'd3
  } dest_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
  } tstamp_t;

  function automatic logic dest_keeps(input logic [1:0] code);
    return (code == DST_BOTH) || (code == DST_DESC);
  endfunction
endpackage

// File: rtl/ts_clock.sv
module ts_clock
  import stamp_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NS_W-1:0] step,
  output tstamp_t         now
);
  localparam logic [NS_W:0] WRAP_X = (NS_W+1)'(NS_WRAP);

  logic [NS_W:0] sum;
  logic          roll;

  always_comb begin
    sum  = {1'b0, now.ns} + {1'b0, step};
    roll = (sum >= WRAP_X);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now <= '0;
    end else if (roll) begin
      now.ns  <= NS_W'(sum - WRAP_X);
      now.sec <= now.sec + 1'b1;
    end else begin
      now.ns  <= sum[NS_W-1:0];
    end
  end

  // R2
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, now.ns} < WRAP_X);

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (now.sec == $past(now.sec)) || (now.sec == $past(now.sec) + 1'b1));

  // R2
  step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, step} < WRAP_X);
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo
  import stamp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  tstamp_t din,
  input  logic    pop,
  output tstamp_t dout,
  output logic    empty,
  output logic    full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  tstamp_t        mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           push_ok;

  assign full    = (cnt == CAP);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R11
  pop_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R10
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  // R10
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/seq_stamper.sv
module seq_stamper
  import stamp_pkg::*;
#(
  parameter int SEQ_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ts_avail,
  input  tstamp_t          ts,
  output logic             ts_pop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_ts_en,
  input  logic             in_seq_en,
  input  logic [1:0]       in_dest,
  input  logic [NS_W-1:0]  in_ts_ns,
  input  logic [SEC_W-1:0] in_ts_sec,
  input  logic [SEQ_W-1:0] in_seq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_dest,
  output logic [NS_W-1:0]  out_ts_ns,
  output logic [SEC_W-1:0] out_ts_sec,
  output logic [SEQ_W-1:0] out_seq
);
  logic             fire, keep;
  logic [SEQ_W-1:0] seq_q;

  assign in_ready = ts_avail && (!out_valid || out_ready);
  assign fire     = in_valid && in_ready;
  assign keep     = fire && dest_keeps(in_dest);
  assign ts_pop   = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_dest   <= DST_DROP;
      out_ts_ns  <= '0;
      out_ts_sec <= '0;
      out_seq    <= '0;
      seq_q      <= '0;
    end else begin
      if (keep) begin
        out_valid  <= 1'b1;
        out_dest   <= in_dest;
        out_ts_ns  <= in_ts_en  ? ts.ns  : in_ts_ns;
        out_ts_sec <= in_ts_en  ? ts.sec : in_ts_sec;
        out_seq    <= in_seq_en ? seq_q  : in_seq;
        seq_q      <= seq_q + 1'b1;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_dest, out_ts_ns, out_ts_sec, out_seq})));

  // R6
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keep |=> (seq_q == $past(seq_q) + 1'b1));

  // R7
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dest_keeps(in_dest) && !out_valid) |=> !out_valid);

  // R8
  dest_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dest_keeps(out_dest));
endmodule

// File: rtl/rx_desc_stamper.sv
module rx_desc_stamper
  import stamp_pkg::*;
#(
  parameter int unsigned NS_WRAP  = 1000000000,
  parameter int          TS_DEPTH = 4,
  parameter int          SEQ_W    = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ns_step,
  input  logic             sop,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_ts_en,
  input  logic             in_seq_en,
  input  logic [1:0]       in_dest,
  input  logic [31:0]      in_ts_ns,
  input  logic [31:0]      in_ts_sec,
  input  logic [SEQ_W-1:0] in_seq,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_dest,
  output logic [31:0]      out_ts_ns,
  output logic [31:0]      out_ts_sec,
  output logic [SEQ_W-1:0] out_seq
);
  tstamp_t now, head;
  logic    q_empty, q_full, q_pop;

  ts_clock #(.NS_WRAP(NS_WRAP)) u_clock (
    .clk  (clk),
    .rst_n(rst_n),
    .step (ns_step),
    .now  (now)
  );

  ts_fifo #(.DEPTH(TS_DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (sop),
    .din  (now),
    .pop  (q_pop),
    .dout (head),
    .empty(q_empty),
    .full (q_full)
  );

  seq_stamper #(.SEQ_W(SEQ_W)) u_stamp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ts_avail  (!q_empty),
    .ts        (head),
    .ts_pop    (q_pop),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_ts_en  (in_ts_en),
    .in_seq_en (in_seq_en),
    .in_dest   (in_dest),
    .in_ts_ns  (in_ts_ns),
    .in_ts_sec (in_ts_sec),
    .in_seq    (in_seq),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_dest  (out_dest),
    .out_ts_ns (out_ts_ns),
    .out_ts_sec(out_ts_sec),
    .out_seq   (out_seq)
  );

  // R11
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !q_full) |-> !q_empty);
endmodule

// File: tb/sim_rx_desc_stamper.sv
module sim_rx_desc_stamper;
  localparam int CLK_PERIOD = 10;
  localparam int WRAP  = 1000;
  localparam int DEPTH = 4;
  localparam int SEQ_W = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ns_step = 32'd7;
  logic sop = 1'b0, in_valid = 1'b0, in_ready;
  logic in_ts_en = 1'b0, in_seq_en = 1'b0;
  logic [1:0] in_dest = 2'd0;
  logic [31:0] in_ts_ns = '0, in_ts_sec = '0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] out_dest;
  logic [31:0] out_ts_ns, out_ts_sec;
  logic [SEQ_W-1:0] out_seq;

  rx_desc_stamper #(.NS_WRAP(WRAP), .TS_DEPTH(DEPTH), .SEQ_W(SEQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ns_step(ns_step), .sop(sop),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts_en(in_ts_en),
    .in_seq_en(in_seq_en), .in_dest(in_dest), .in_ts_ns(in_ts_ns),
    .in_ts_sec(in_ts_sec), .in_seq(in_seq), .out_valid(out_valid),
    .out_ready(out_ready), .out_dest(out_dest), .out_ts_ns(out_ts_ns),
    .out_ts_sec(out_ts_sec), .out_seq(out_seq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]       d;
    logic [31:0]      sec;
    logic [31:0]      ns;
    logic [SEQ_W-1:0] sq;
  } exp_t;

  logic [63:0]      m_tsq [$];
  exp_t             m_expq [$];
  logic [31:0]      m_ns = '0, m_sec = '0;
  logic [SEQ_W-1:0] m_seq = '0;
  int               n0;
  logic [63:0]      tsv;
  logic [32:0]      nsum;
  exp_t             e;

  // Reference model, evaluated between edges: it predicts the next edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ns = '0; m_sec = '0; m_seq = '0;
      m_tsq.delete(); m_expq.delete();
    end else begin
      n0 = m_tsq.size();
      chk(out_valid == (m_expq.size() != 0), "R9", "out_valid",
          64'(out_valid), 64'(m_expq.size() != 0));
      chk(in_ready == ((n0 != 0) && (m_expq.size() == 0 || out_ready)), "R11",
          "in_ready", 64'(in_ready), 64'((n0 != 0) && (m_expq.size() == 0 || out_ready)));
      if (out_valid && m_expq.size() != 0) begin
        e = m_expq[0];
        chk(out_dest == e.d, "R8", "out_dest", 64'(out_dest), 64'(e.d));
        chk(out_ts_ns == e.ns, "R2 R3 R4", "out_ts_ns", 64'(out_ts_ns), 64'(e.ns));
        chk(out_ts_sec == e.sec, "R2 R3 R4", "out_ts_sec", 64'(out_ts_sec), 64'(e.sec));
        chk(out_seq == e.sq, "R5 R6", "out_seq", 64'(out_seq), 64'(e.sq));
        if (out_ready) void'(m_expq.pop_front());
      end
      if (in_valid && in_ready && n0 != 0) begin
        tsv = m_tsq.pop_front();
        if (in_dest == 2'd1 || in_dest == 2'd2) begin
          e.d   = in_dest;
          e.ns  = in_ts_en ? tsv[31:0]  : in_ts_ns;
          e.sec = in_ts_en ? tsv[63:32] : in_ts_sec;
          e.sq  = in_seq_en ? m_seq : in_seq;
          m_seq = m_seq + 1'b1;
          m_expq.push_back(e);
        end
      end
      // R10: capture only when the queue held fewer than DEPTH before the edge
      if (sop && n0 < DEPTH) m_tsq.push_back({m_sec, m_ns});
      nsum = {1'b0, m_ns} + {1'b0, ns_step};
      if (nsum >= 33'(WRAP)) begin
        m_ns  = 32'(nsum - 33'(WRAP));
        m_sec = m_sec + 1'b1;
      end else begin
        m_ns = nsum[31:0];
      end
    end
  end

  // Back-pressure patterns on the output side
  int bp_mode = 0, bcyc = 0;
  always @(posedge clk) begin
    #1;
    bcyc++;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = (bcyc % 3) != 0;
      2: out_ready = (bcyc % 5) < 2;
      default: out_ready = (bcyc % 7) == 0;
    endcase
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse_sop();
    sop = 1'b1; tick(); sop = 1'b0;
  endtask

  task automatic push_desc(input bit te, input bit se, input logic [1:0] d,
                           input int tag);
    in_valid  = 1'b1;
    in_ts_en  = te;
    in_seq_en = se;
    in_dest   = d;
    in_ts_ns  = 32'hC000_0000 | 32'(tag);
    in_ts_sec = 32'h5EC0_0000 | 32'(tag);
    in_seq    = 48'hABCD_0000_0000 | 48'(tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic send(input bit te, input bit se, input logic [1:0] d,
                      input int gap, input int tag);
    pulse_sop();
    repeat (gap) tick();
    push_desc(te, se, d, tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R1", "in_ready after reset", 64'(in_ready), 64'd0);
    @(posedge clk); #1;

    // Sweep of enables x destination codes x back-pressure (R3 R4 R5 R6 R7 R8 R9)
    ns_step = 32'd7;
    for (int i = 0; i < 64; i++) begin
      bp_mode = (i >> 4) & 3;
      send(i[0], i[1], 2'(i >> 2), i % 3, i);
    end

    // R2: steps that force frequent rollover
    bp_mode = 1;
    ns_step = 32'd333;
    for (int i = 0; i < 16; i++) send(1'b1, 1'b1, 2'd1, i % 4, 100 + i);
    ns_step = 32'd999;
    for (int i = 0; i < 8; i++) send(1'b1, i[0], 2'd2, i % 2, 200 + i);

    // R10: more starts of packet than the queue holds
    bp_mode = 0;
    ns_step = 32'd11;
    repeat (DEPTH + 2) pulse_sop();
    for (int i = 0; i < DEPTH; i++) push_desc(1'b1, 1'b1, 2'd1, 300 + i);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10", "in_ready after queue drained", 64'(in_ready), 64'd0);
    @(posedge clk); #1;

    // R7: drop codes leave no output
    send(1'b1, 1'b1, 2'd0, 1, 400);
    repeat (3) tick();
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid after code 0", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    send(1'b1, 1'b1, 2'd3, 0, 401);
    repeat (3) tick();
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "out_valid after code 3", 64'(out_valid), 64'd0);
    @(posedge clk); #1;
    send(1'b0, 1'b1, 2'd1, 0, 402);

    repeat (10) tick();
    chk(m_expq.size() == 0, "R9", "outputs left undelivered", 64'(m_expq.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule